// File: doc/BRIEF.md
# Pipeline operand forwarding unit

A purely combinational bypass network for a five-stage integer pipeline. For each of the two source operands held in the ID/Ex pipeline register, it decides whether the register-file value is stale. If it is, it substitutes a newer result that is still in flight.

There are three candidate sources. The first two come from the Ex/Mem stage: the ALU result, or an upper-immediate value when that instruction writes back an immediate. The third is the final writeback value already selected at the Mem/WB stage. The newest producer always wins.

The unit emits a 2-bit select code and the forwarded 32-bit value per operand. The forwarded first operand also serves as the base for the branch/jump target adder. The forwarded second operand also serves as the store data passed on to Ex/Mem.

The unit does not ask whether the instruction actually reads a register. Operands that are not used are dropped by the ALU-source muxes further down the datapath.

Top module: `fwd_unit`

## Requirements
- R1: When an operand's source index equals the Ex/Mem destination index, the Ex/Mem write enable is 1, the destination is nonzero, and the Ex/Mem writeback code is not 3, the select code is 2'b01 and the operand equals the Ex/Mem ALU result. This holds for writeback codes 0 (ALU), 1 (load) and 2 (PC+4).
- R2: Under the same Ex/Mem match, when the Ex/Mem writeback code is 3 (immediate), the select code is 2'b10 and the operand equals the Ex/Mem immediate.
- R3: When there is no Ex/Mem match, and the source index equals the Mem/WB destination index, the Mem/WB write enable is 1 and that destination is nonzero, the select code is 2'b11 and the operand equals the Mem/WB writeback value.
- R4: When both the Ex/Mem and the Mem/WB conditions hold for one operand, the Ex/Mem source is chosen (select 2'b01 or 2'b10).
- R5: When neither condition holds, the select code is 2'b00 and the operand equals its register-file value. A destination index of 0 never forwards, whatever the write enables are.
- R6: Operand 0 (rs1) and operand 1 (rs2) are decided independently, so each can take a different select code at the same time.
- R7: The branch-target base output always equals forwarded operand 0, and the store-data output always equals forwarded operand 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idex_src_idx_i | input | 2x5 | Source register indices in ID/Ex; entry 0 is rs1, entry 1 is rs2 |
| idex_src_val_i | input | 2x32 | Register-file read values for the two sources |
| exm_dst_idx_i | input | 5 | Ex/Mem destination index |
| exm_wr_en_i | input | 1 | Ex/Mem register write enable |
| exm_wb_sel_i | input | 2 | Ex/Mem writeback code: 0 ALU, 1 load, 2 PC+4, 3 immediate |
| exm_alu_res_i | input | 32 | Ex/Mem ALU result |
| exm_imm_i | input | 32 | Ex/Mem upper-immediate value |
| mwb_dst_idx_i | input | 5 | Mem/WB destination index |
| mwb_wr_en_i | input | 1 | Mem/WB register write enable |
| mwb_wb_val_i | input | 32 | Mem/WB selected writeback value |
| fwd_sel_o | output | 2x2 | Per-operand select: 00 none, 01 Ex/Mem ALU, 10 Ex/Mem imm, 11 Mem/WB |
| fwd_opnd_o | output | 2x32 | Forwarded operand values |
| tgt_base_o | output | 32 | Operand 0 value for the branch/jump target adder |
| st_data_o | output | 32 | Operand 1 value as store data |

## Verification
The hardest situation to reach from the ports is one where both pipeline stages match the same operand and the newer one points at register 0 or has its write enable off. In that case priority must fall back to Mem/WB, or to no forwarding at all.

Uniform random 5-bit indices would almost never line up. The stimulus therefore draws every index from registers 0 to 3 and toggles the enables at random, so that double matches and zero-register matches occur on many cycles.

Directed cycles then set up the stage-overlap, register-0, immediate and mixed-operand cases explicitly. Each of these is compared against a behavioural model.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int NUM_SRC = 2;  // rs1, rs2

  typedef enum logic [1:0] {
    FWD_NONE    = 2'b00,
    FWD_EXM_ALU = 2'b01,
    FWD_EXM_IMM = 2'b10,
    FWD_MWB     = 2'b11
  } fwd_sel_e;

  typedef enum logic [1:0] {
    WB_ALU  = 2'd0,
    WB_LOAD = 2'd1,
    WB_PC4  = 2'd2,
    WB_IMM  = 2'd3
  } wb_sel_e;
endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src_idx_i,
  input  logic [AW-1:0] dst_idx_i,
  input  logic          dst_we_i,
  output logic          hit_o
);
  assign hit_o = dst_we_i && (dst_idx_i != '0) && (src_idx_i == dst_idx_i);
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
  import fwd_pkg::*;
(
  input  logic       exm_hit_i,
  input  logic       mwb_hit_i,
  input  logic [1:0] exm_wb_sel_i,
  output logic [1:0] sel_o
);
  fwd_sel_e sel;

  always_comb begin
    if (exm_hit_i) begin
      // newer producer first
      sel = (exm_wb_sel_i == WB_IMM) ? FWD_EXM_IMM : FWD_EXM_ALU;
    end else if (mwb_hit_i) begin
      sel = FWD_MWB;
    end else begin
      sel = FWD_NONE;
    end
  end

  assign sel_o = sel;
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
  import fwd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [1:0]      sel_i,
  input  logic [XLEN-1:0] rf_val_i,
  input  logic [XLEN-1:0] alu_val_i,
  input  logic [XLEN-1:0] imm_val_i,
  input  logic [XLEN-1:0] wb_val_i,
  output logic [XLEN-1:0] val_o
);
  always_comb begin
    unique case (sel_i)
      FWD_EXM_ALU: val_o = alu_val_i;
      FWD_EXM_IMM: val_o = imm_val_i;
      FWD_MWB:     val_o = wb_val_i;
      default:     val_o = rf_val_i;
    endcase
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input  logic [NUM_SRC-1:0][AW-1:0]   idex_src_idx_i,
  input  logic [NUM_SRC-1:0][XLEN-1:0] idex_src_val_i,
  input  logic [AW-1:0]                exm_dst_idx_i,
  input  logic                         exm_wr_en_i,
  input  logic [1:0]                   exm_wb_sel_i,
  input  logic [XLEN-1:0]              exm_alu_res_i,
  input  logic [XLEN-1:0]              exm_imm_i,
  input  logic [AW-1:0]                mwb_dst_idx_i,
  input  logic                         mwb_wr_en_i,
  input  logic [XLEN-1:0]              mwb_wb_val_i,
  output logic [NUM_SRC-1:0][1:0]      fwd_sel_o,
  output logic [NUM_SRC-1:0][XLEN-1:0] fwd_opnd_o,
  output logic [XLEN-1:0]              tgt_base_o,
  output logic [XLEN-1:0]              st_data_o
);
  logic [NUM_SRC-1:0] exm_hit;
  logic [NUM_SRC-1:0] mwb_hit;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    fwd_hit #(.AW(AW)) exm_hit_i (
      .src_idx_i (idex_src_idx_i[s]),
      .dst_idx_i (exm_dst_idx_i),
      .dst_we_i  (exm_wr_en_i),
      .hit_o     (exm_hit[s])
    );

    fwd_hit #(.AW(AW)) mwb_hit_i (
      .src_idx_i (idex_src_idx_i[s]),
      .dst_idx_i (mwb_dst_idx_i),
      .dst_we_i  (mwb_wr_en_i),
      .hit_o     (mwb_hit[s])
    );

    fwd_pick pick_i (
      .exm_hit_i    (exm_hit[s]),
      .mwb_hit_i    (mwb_hit[s]),
      .exm_wb_sel_i (exm_wb_sel_i),
      .sel_o        (fwd_sel_o[s])
    );

    fwd_mux #(.XLEN(XLEN)) mux_i (
      .sel_i     (fwd_sel_o[s]),
      .rf_val_i  (idex_src_val_i[s]),
      .alu_val_i (exm_alu_res_i),
      .imm_val_i (exm_imm_i),
      .wb_val_i  (mwb_wb_val_i),
      .val_o     (fwd_opnd_o[s])
    );
  end

  assign tgt_base_o = fwd_opnd_o[0];
  assign st_data_o  = fwd_opnd_o[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk
  import fwd_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input logic [NUM_SRC-1:0][AW-1:0]   idex_src_idx_i,
  input logic [NUM_SRC-1:0][XLEN-1:0] idex_src_val_i,
  input logic [AW-1:0]                exm_dst_idx_i,
  input logic                         exm_wr_en_i,
  input logic [1:0]                   exm_wb_sel_i,
  input logic [XLEN-1:0]              exm_alu_res_i,
  input logic [XLEN-1:0]              exm_imm_i,
  input logic [AW-1:0]                mwb_dst_idx_i,
  input logic                         mwb_wr_en_i,
  input logic [XLEN-1:0]              mwb_wb_val_i,
  input logic [NUM_SRC-1:0][1:0]      fwd_sel_o,
  input logic [NUM_SRC-1:0][XLEN-1:0] fwd_opnd_o,
  input logic [XLEN-1:0]              tgt_base_o,
  input logic [XLEN-1:0]              st_data_o
);
  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) begin
      if (fwd_sel_o[s] == 2'b01)
        assert_alu_val_R1: assert (fwd_opnd_o[s] == exm_alu_res_i && exm_wb_sel_i != 2'd3 && exm_wr_en_i);
      if (fwd_sel_o[s] == 2'b10)
        assert_imm_val_R2: assert (fwd_opnd_o[s] == exm_imm_i && exm_wb_sel_i == 2'd3 && exm_wr_en_i);
      if (fwd_sel_o[s] == 2'b11)
        assert_mwb_val_R3: assert (fwd_opnd_o[s] == mwb_wb_val_i && mwb_wr_en_i && mwb_dst_idx_i != '0
                                   && !(exm_wr_en_i && exm_dst_idx_i == idex_src_idx_i[s]));
      if (exm_wr_en_i && exm_dst_idx_i != '0 && exm_dst_idx_i == idex_src_idx_i[s])
        assert_exm_first_R4: assert (fwd_sel_o[s] == 2'b01 || fwd_sel_o[s] == 2'b10);
      if (idex_src_idx_i[s] == '0)
        assert_zero_reg_R5: assert (fwd_sel_o[s] == 2'b00 && fwd_opnd_o[s] == idex_src_val_i[s]);
    end
    assert_side_outs_R7: assert (tgt_base_o == fwd_opnd_o[0] && st_data_o == fwd_opnd_o[1]);
  end
endmodule

bind fwd_unit fwd_unit_chk #(.XLEN(XLEN), .AW(AW)) chk_i (
  .idex_src_idx_i (idex_src_idx_i),
  .idex_src_val_i (idex_src_val_i),
  .exm_dst_idx_i  (exm_dst_idx_i),
  .exm_wr_en_i    (exm_wr_en_i),
  .exm_wb_sel_i   (exm_wb_sel_i),
  .exm_alu_res_i  (exm_alu_res_i),
  .exm_imm_i      (exm_imm_i),
  .mwb_dst_idx_i  (mwb_dst_idx_i),
  .mwb_wr_en_i    (mwb_wr_en_i),
  .mwb_wb_val_i   (mwb_wb_val_i),
  .fwd_sel_o      (fwd_sel_o),
  .fwd_opnd_o     (fwd_opnd_o),
  .tgt_base_o     (tgt_base_o),
  .st_data_o      (st_data_o)
);

// File: tb/fwd_unit_tb_top.sv
`timescale 1ns/1ps
module fwd_unit_tb_top;
  localparam int XLEN = 32;
  localparam int AW   = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0][AW-1:0]   src_idx;
  logic [1:0][XLEN-1:0] src_val;
  logic [AW-1:0]        exm_dst;
  logic                 exm_we;
  logic [1:0]           exm_wb;
  logic [XLEN-1:0]      exm_alu, exm_imm;
  logic [AW-1:0]        mwb_dst;
  logic                 mwb_we;
  logic [XLEN-1:0]      mwb_val;
  logic [1:0][1:0]      sel;
  logic [1:0][XLEN-1:0] opnd;
  logic [XLEN-1:0]      tgt, std;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  fwd_unit #(.XLEN(XLEN), .AW(AW)) dut_i (
    .idex_src_idx_i (src_idx), .idex_src_val_i (src_val),
    .exm_dst_idx_i (exm_dst), .exm_wr_en_i (exm_we), .exm_wb_sel_i (exm_wb),
    .exm_alu_res_i (exm_alu), .exm_imm_i (exm_imm),
    .mwb_dst_idx_i (mwb_dst), .mwb_wr_en_i (mwb_we), .mwb_wb_val_i (mwb_val),
    .fwd_sel_o (sel), .fwd_opnd_o (opnd), .tgt_base_o (tgt), .st_data_o (std)
  );

  // behavioural expectation for one operand
  task automatic expect_op(input int s, output logic [1:0] es, output logic [XLEN-1:0] ev);
    bit newer, older;
    newer = exm_we && exm_dst != 0 && exm_dst == src_idx[s];
    older = mwb_we && mwb_dst != 0 && mwb_dst == src_idx[s];
    if (newer && exm_wb == 2'd3) begin es = 2'b10; ev = exm_imm; end
    else if (newer)              begin es = 2'b01; ev = exm_alu; end
    else if (older)              begin es = 2'b11; ev = mwb_val; end
    else                         begin es = 2'b00; ev = src_val[s]; end
  endtask

  task automatic check_op(input int s, input string tag);
    logic [1:0] es;
    logic [XLEN-1:0] ev;
    expect_op(s, es, ev);
    if (tag == "") tag = (es == 2'b00) ? "R5" : (es == 2'b01) ? "R1" : (es == 2'b10) ? "R2" : "R3";
    n_run++;
    if (sel[s] !== es || opnd[s] !== ev) begin
      n_fail++;
      $display("FAIL %s op%0d: sel=%b val=%h expected sel=%b val=%h", tag, s, sel[s], opnd[s], es, ev);
    end
  endtask

  task automatic check_side();
    n_run++;
    if (tgt !== opnd[0] || std !== opnd[1]) begin
      n_fail++;
      $display("FAIL R7: tgt=%h st=%h expected %h %h", tgt, std, opnd[0], opnd[1]);
    end
  endtask

  task automatic check_sel(input int s, input logic [1:0] es, input string tag);
    n_run++;
    if (sel[s] !== es) begin
      n_fail++;
      $display("FAIL %s op%0d: sel=%b expected sel=%b", tag, s, sel[s], es);
    end
  endtask

  task automatic drive(input logic [AW-1:0] i0, i1, ed, input logic ew, input logic [1:0] wb,
                       input logic [AW-1:0] md, input logic mw);
    @(posedge clk); #1;
    src_idx[0] = i0; src_idx[1] = i1;
    src_val[0] = 32'h1111_0000 | $urandom_range(0, 255);
    src_val[1] = 32'h2222_0000 | $urandom_range(0, 255);
    exm_dst = ed; exm_we = ew; exm_wb = wb;
    exm_alu = 32'hA1A1_0000 | $urandom_range(0, 255);
    exm_imm = 32'h003F_F000;
    mwb_dst = md; mwb_we = mw;
    mwb_val = 32'hB2B2_0000 | $urandom_range(0, 255);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    src_idx = '0; src_val = '0; exm_dst = '0; exm_we = 0; exm_wb = 0;
    exm_alu = '0; exm_imm = '0; mwb_dst = '0; mwb_we = 0; mwb_val = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_op(0, "R5 reset"); check_op(1, "R5 reset");
    rst_ni = 1'b1;

    // R1: ALU-type codes 0,1,2 all forward ALU result
    for (int c = 0; c < 3; c++) begin
      drive(5'd7, 5'd9, 5'd7, 1, c[1:0], 5'd0, 0);
      check_sel(0, 2'b01, "R1"); check_op(0, "R1");
    end
    // R2: immediate code
    drive(5'd8, 5'd3, 5'd8, 1, 2'd3, 5'd0, 0);
    check_sel(0, 2'b10, "R2"); check_op(0, "R2");
    // R3: Mem/WB only
    drive(5'd4, 5'd12, 5'd5, 1, 2'd0, 5'd12, 1);
    check_sel(1, 2'b11, "R3"); check_op(1, "R3");
    // R4: both stages match same register
    drive(5'd6, 5'd6, 5'd6, 1, 2'd0, 5'd6, 1);
    check_sel(0, 2'b01, "R4"); check_sel(1, 2'b01, "R4");
    drive(5'd6, 5'd2, 5'd6, 1, 2'd3, 5'd6, 1);
    check_sel(0, 2'b10, "R4"); check_op(0, "R4");
    // R4: newer stage disabled falls back to older
    drive(5'd6, 5'd2, 5'd6, 0, 2'd0, 5'd6, 1);
    check_sel(0, 2'b11, "R4"); check_op(0, "R4");
    // R5: register 0 never forwards
    drive(5'd0, 5'd0, 5'd0, 1, 2'd3, 5'd0, 1);
    check_sel(0, 2'b00, "R5"); check_op(0, "R5"); check_op(1, "R5");
    // R5: no enable
    drive(5'd10, 5'd11, 5'd10, 0, 2'd0, 5'd11, 0);
    check_sel(0, 2'b00, "R5"); check_sel(1, 2'b00, "R5");
    // R6: operands independent
    drive(5'd13, 5'd14, 5'd13, 1, 2'd3, 5'd14, 1);
    check_sel(0, 2'b10, "R6"); check_sel(1, 2'b11, "R6"); check_side();
    drive(5'd15, 5'd13, 5'd13, 1, 2'd1, 5'd0, 1);
    check_sel(0, 2'b00, "R6"); check_sel(1, 2'b01, "R6"); check_side();

    // random sweep over a small register window
    for (int k = 0; k < 3000; k++) begin
      drive(AW'($urandom_range(0, 3)), AW'($urandom_range(0, 3)), AW'($urandom_range(0, 3)),
            1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
            AW'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
      check_op(0, ""); check_op(1, ""); check_side();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule